// File: doc/BRIEF.md
# Single-Cycle Load/Store Processor Core

This block is a 32-bit processor that fetches, decodes, executes and retires one instruction in every clock cycle. It implements a small load/store subset: six register-register ALU operations, add-immediate, word load, word store, branch-on-equal and absolute jump. The program counter, the 32-entry register file and the data memory all commit on the same rising edge. Nothing in the machine holds a partially finished instruction.

Control is hardwired. Every steering and enable signal is a combinational function of the opcode and function fields of the word fetched at the current PC. Instruction memory and data memory are internal word arrays. They are filled through a preload port while reset is held. Two debug views are brought out: the PC of the instruction now executing, and the register write that instruction will commit at the coming edge.

Top module: `scc_core`

## Requirements
- R1: An active-low `rst_n` asynchronously clears the PC to 0 and all registers to 0. Its release passes through a two-stage synchronizer. The PC stays 0 and `dbg_rf_we` stays 0 until the synchronizer has released, so the first instruction commits on the third rising edge after `rst_n` goes high.
- R2: While `rst_n` is low, a rising edge with `pre_we` high writes `pre_wdata` into word `pre_addr`. The target is instruction memory when `pre_dmem` is 0 and data memory when it is 1. While `rst_n` is high the preload port has no effect.
- R3: Instruction fields are opcode [31:26], rs [25:21], rt [20:16], rd [15:11] and funct [5:0]. Opcode 0x00 writes rd with rs op rt, where the op is selected by funct: 0x20 add, 0x22 subtract, 0x24 AND, 0x25 OR, 0x26 XOR, 0x27 NOR.
- R4: Opcode 0x08 writes rt with rs plus the sign-extended immediate [15:0].
- R5: For opcode 0x23 (load) and opcode 0x2B (store), the address is rs plus the sign-extended immediate, and the memory word is selected by address bits [9:2]. A load writes that word into rt. A store writes rt into that word, writes no register, and is visible to a later load.
- R6: Opcode 0x04 compares rs and rt. When they are equal, the next PC is PC+4 plus the sign-extended immediate shifted left by 2. Otherwise the next PC is PC+4. No register is written.
- R7: Opcode 0x02 sets the PC to {(PC+4)[31:28], inst[25:0], 2'b00} and writes no register.
- R8: Register 0 always reads as 0. A write aimed at it is discarded, and `dbg_rf_we` stays low for it.
- R9: Any other opcode, and opcode 0x00 with any other funct, writes no register, stores nothing and advances the PC by 4.
- R10: When an instruction's destination is also one of its sources, the sources read the value from before the edge, and the new value appears only after that edge.
- R11: `dbg_pc` shows the address of the instruction executing now. `dbg_rf_we`, `dbg_rf_waddr` and `dbg_rf_wdata` show the register write that instruction commits at the next rising edge. Instruction memory is indexed by PC bits [9:2].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released through a synchronizer |
| pre_we | input | 1 | Preload write strobe, honoured only while rst_n is low |
| pre_dmem | input | 1 | Preload target: 0 instruction memory, 1 data memory |
| pre_addr | input | PAW (8) | Preload word index |
| pre_wdata | input | 32 | Preload data word |
| dbg_pc | output | 32 | Address of the executing instruction |
| dbg_rf_we | output | 1 | A register write commits at the next edge |
| dbg_rf_waddr | output | 5 | Destination register of that write |
| dbg_rf_wdata | output | 32 | Value of that write |

## Verification
The functions that meet in one cycle are the register-file read and the register-file write of the same register. This happens when an instruction names its destination as a source, for example adding a register to itself. A directed case provokes it, and random programs also hit it often because they draw operands from only eight registers. The bench runs its own instruction-level model in lockstep and compares every write value and every PC against that model, which always reads the value from before the edge. Store-then-load to the same word and preload pulses during execution are judged the same way: a wrong memory word shows up later as a wrong register write.

// File: rtl/scc_pkg.sv
package scc_pkg;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int unsigned WORD_W  = 32;
  localparam int unsigned REG_CNT = 32;
  localparam int unsigned REG_AW  = $clog2(REG_CNT);

  // Opcodes (inst[31:26])
  localparam logic [5:0] OPC_RTYPE = 6'h00;
  localparam logic [5:0] OPC_JMP   = 6'h02;
  localparam logic [5:0] OPC_BEQ   = 6'h04;
  localparam logic [5:0] OPC_ADDI  = 6'h08;
  localparam logic [5:0] OPC_LOAD  = 6'h23;
  localparam logic [5:0] OPC_STORE = 6'h2B;

  // Function codes (inst[5:0]) for opcode 0
  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_XOR = 6'h26;
  localparam logic [5:0] FN_NOR = 6'h27;

  typedef enum logic [2:0] {
    ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_XOR, ALU_NOR
  } alu_op_e;

  typedef struct packed {
    logic    reg_we;   // register file write
    logic    dst_rd;   // destination rd instead of rt
    logic    src_imm;  // second operand is the immediate
    logic    wb_mem;   // write back the loaded word
    logic    mem_we;   // data memory write
    logic    branch;   // conditional branch on equal
    logic    jump;     // absolute jump
    alu_op_e alu_op;
  } ctrl_t;
endpackage

// File: rtl/scc_ctrl.sv
module scc_ctrl
  import scc_pkg::*;
(
  input  logic [5:0] opcode,
  input  logic [5:0] funct,
  output ctrl_t      ctl
);
  timeunit 1ns;
  timeprecision 1ps;

  always_comb begin
    ctl        = '0;
    ctl.alu_op = ALU_ADD;
    case (opcode)
      OPC_RTYPE: begin
        ctl.dst_rd = 1'b1;
        case (funct)
          FN_ADD: begin ctl.reg_we = 1'b1; ctl.alu_op = ALU_ADD; end
          FN_SUB: begin ctl.reg_we = 1'b1; ctl.alu_op = ALU_SUB; end
          FN_AND: begin ctl.reg_we = 1'b1; ctl.alu_op = ALU_AND; end
          FN_OR:  begin ctl.reg_we = 1'b1; ctl.alu_op = ALU_OR;  end
          FN_XOR: begin ctl.reg_we = 1'b1; ctl.alu_op = ALU_XOR; end
          FN_NOR: begin ctl.reg_we = 1'b1; ctl.alu_op = ALU_NOR; end
          default: ;
        endcase
      end
      OPC_ADDI: begin
        ctl.reg_we  = 1'b1;
        ctl.src_imm = 1'b1;
      end
      OPC_LOAD: begin
        ctl.reg_we  = 1'b1;
        ctl.src_imm = 1'b1;
        ctl.wb_mem  = 1'b1;
      end
      OPC_STORE: begin
        ctl.src_imm = 1'b1;
        ctl.mem_we  = 1'b1;
      end
      OPC_BEQ: begin
        ctl.branch = 1'b1;
        ctl.alu_op = ALU_SUB;
      end
      OPC_JMP: ctl.jump = 1'b1;
      default: ;
    endcase
  end
endmodule

// File: rtl/scc_alu.sv
module scc_alu
  import scc_pkg::*;
(
  input  logic [WORD_W-1:0] opa,
  input  logic [WORD_W-1:0] opb,
  input  alu_op_e           op,
  output logic [WORD_W-1:0] res,
  output logic              zero
);
  timeunit 1ns;
  timeprecision 1ps;

  always_comb begin
    case (op)
      ALU_ADD: res = opa + opb;
      ALU_SUB: res = opa - opb;
      ALU_AND: res = opa & opb;
      ALU_OR:  res = opa | opb;
      ALU_XOR: res = opa ^ opb;
      ALU_NOR: res = ~(opa | opb);
      default: res = opa + opb;
    endcase
  end

  assign zero = (res == '0);
endmodule

// File: rtl/scc_regfile.sv
module scc_regfile
  import scc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [REG_AW-1:0] waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic [REG_AW-1:0] ra,
  input  logic [REG_AW-1:0] rb,
  output logic [WORD_W-1:0] rda,
  output logic [WORD_W-1:0] rdb
);
  timeunit 1ns;
  timeprecision 1ps;

  logic [WORD_W-1:0] rf_q [REG_CNT];

  for (genvar g = 0; g < REG_CNT; g++) begin : g_reg
    if (g == 0) begin : g_zero
      assign rf_q[g] = '0;
    end else begin : g_flop
      logic [WORD_W-1:0] q, d;
      always_comb d = (we && waddr == REG_AW'(g)) ? wdata : q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
      end
      assign rf_q[g] = q;
    end
  end

  assign rda = rf_q[ra];
  assign rdb = rf_q[rb];
endmodule

// File: rtl/scc_mem.sv
module scc_mem
  import scc_pkg::*;
#(
  parameter  int unsigned DEPTH = 256,
  localparam int unsigned AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [WORD_W-1:0] rdata
);
  timeunit 1ns;
  timeprecision 1ps;

  logic [WORD_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem_q[waddr] <= wdata;
  end

  assign rdata = mem_q[raddr];
endmodule

// File: rtl/scc_core.sv
module scc_core
  import scc_pkg::*;
#(
  parameter  int unsigned IMEM_WORDS  = 256,
  parameter  int unsigned DMEM_WORDS  = 256,
  parameter  int unsigned SYNC_STAGES = 2,
  localparam int unsigned IAW = $clog2(IMEM_WORDS),
  localparam int unsigned DAW = $clog2(DMEM_WORDS),
  localparam int unsigned PAW = (IAW > DAW) ? IAW : DAW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pre_we,
  input  logic              pre_dmem,
  input  logic [PAW-1:0]    pre_addr,
  input  logic [WORD_W-1:0] pre_wdata,
  output logic [WORD_W-1:0] dbg_pc,
  output logic              dbg_rf_we,
  output logic [REG_AW-1:0] dbg_rf_waddr,
  output logic [WORD_W-1:0] dbg_rf_wdata
);
  timeunit 1ns;
  timeprecision 1ps;

  // reset release synchronizer
  logic [SYNC_STAGES-1:0] sync_q, sync_d;
  logic                   run;

  always_comb sync_d = {sync_q[SYNC_STAGES-2:0], 1'b1};
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end
  assign run = sync_q[SYNC_STAGES-1];

  // datapath signals
  logic [WORD_W-1:0] pc_q, pc_d, pc_plus4, br_tgt, jmp_tgt;
  logic [WORD_W-1:0] inst, imm_sx, rs_val, rt_val, alu_b, alu_y, ld_val, wb_data;
  logic [REG_AW-1:0] dst;
  logic              alu_zero, load_phase, st_we, dm_we, rf_we;
  logic [DAW-1:0]    dm_waddr;
  logic [WORD_W-1:0] dm_wdata;
  ctrl_t             ctl;

  assign load_phase = !rst_n;

  // instruction memory: written only by preload
  scc_mem #(.DEPTH(IMEM_WORDS)) u_imem (
    .clk   (clk),
    .we    (load_phase & pre_we & !pre_dmem),
    .waddr (pre_addr[IAW-1:0]),
    .wdata (pre_wdata),
    .raddr (pc_q[IAW+1:2]),
    .rdata (inst)
  );

  scc_ctrl u_ctrl (
    .opcode (inst[31:26]),
    .funct  (inst[5:0]),
    .ctl    (ctl)
  );

  always_comb begin
    imm_sx   = {{(WORD_W-16){inst[15]}}, inst[15:0]};
    dst      = ctl.dst_rd ? inst[15:11] : inst[20:16];
    alu_b    = ctl.src_imm ? imm_sx : rt_val;
    wb_data  = ctl.wb_mem ? ld_val : alu_y;
    rf_we    = run & ctl.reg_we;
  end

  scc_regfile u_rf (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (rf_we),
    .waddr (dst),
    .wdata (wb_data),
    .ra    (inst[25:21]),
    .rb    (inst[20:16]),
    .rda   (rs_val),
    .rdb   (rt_val)
  );

  scc_alu u_alu (
    .opa  (rs_val),
    .opb  (alu_b),
    .op   (ctl.alu_op),
    .res  (alu_y),
    .zero (alu_zero)
  );

  // data memory: preload port during reset, store path while running
  always_comb begin
    st_we    = run & ctl.mem_we;
    dm_we    = (load_phase & pre_we & pre_dmem) | st_we;
    dm_waddr = load_phase ? pre_addr[DAW-1:0] : alu_y[DAW+1:2];
    dm_wdata = load_phase ? pre_wdata : rt_val;
  end

  scc_mem #(.DEPTH(DMEM_WORDS)) u_dmem (
    .clk   (clk),
    .we    (dm_we),
    .waddr (dm_waddr),
    .wdata (dm_wdata),
    .raddr (alu_y[DAW+1:2]),
    .rdata (ld_val)
  );

  // next PC
  always_comb begin
    pc_plus4 = pc_q + WORD_W'(4);
    br_tgt   = pc_plus4 + {imm_sx[WORD_W-3:0], 2'b00};
    jmp_tgt  = {pc_plus4[WORD_W-1:28], inst[25:0], 2'b00};
    if (ctl.jump)                    pc_d = jmp_tgt;
    else if (ctl.branch && alu_zero) pc_d = br_tgt;
    else                             pc_d = pc_plus4;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   pc_q <= '0;
    else if (run) pc_q <= pc_d;
  end

  assign dbg_pc       = pc_q;
  assign dbg_rf_we    = rf_we & (dst != '0);
  assign dbg_rf_waddr = dst;
  assign dbg_rf_wdata = wb_data;
endmodule

// File: rtl/scc_core_chk.sv
module scc_core_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        run,
  input logic [31:0] pc,
  input logic        rf_we,
  input logic [4:0]  rf_waddr,
  input logic        is_branch,
  input logic        is_jump,
  input logic [25:0] jmp_field,
  input logic        st_we,
  input logic [31:0] rs_val,
  input logic [31:0] rt_val
);
  timeunit 1ns;
  timeprecision 1ps;

  assert_hold_until_sync_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> (pc == 32'd0 && !rf_we));

  assert_seq_advance_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !is_branch && !is_jump) |=> pc == $past(pc) + 32'd4);

  assert_branch_fallthru_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (run && is_branch && rs_val != rt_val) |=> pc == $past(pc) + 32'd4);

  assert_jump_target_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (run && is_jump) |=> pc[27:0] == {$past(jmp_field), 2'b00});

  assert_no_zero_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> rf_waddr != 5'd0);

  assert_store_no_wb_R5: assert property (@(posedge clk) disable iff (!rst_n)
    st_we |-> !rf_we);
endmodule

bind scc_core scc_core_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .run       (run),
  .pc        (pc_q),
  .rf_we     (dbg_rf_we),
  .rf_waddr  (dbg_rf_waddr),
  .is_branch (ctl.branch),
  .is_jump   (ctl.jump),
  .jmp_field (inst[25:0]),
  .st_we     (st_we),
  .rs_val    (rs_val),
  .rt_val    (rt_val)
);

// File: tb/sim_scc_core.sv
module sim_scc_core;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int WORDS = 256;
  localparam int WATCHDOG = 30000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pre_we = 1'b0;
  logic        pre_dmem = 1'b0;
  logic [7:0]  pre_addr = '0;
  logic [31:0] pre_wdata = '0;
  logic [31:0] dbg_pc;
  logic        dbg_rf_we;
  logic [4:0]  dbg_rf_waddr;
  logic [31:0] dbg_rf_wdata;

  always #4 clk = ~clk;  // 125 MHz

  scc_core u0 (
    .clk (clk), .rst_n (rst_n), .pre_we (pre_we), .pre_dmem (pre_dmem),
    .pre_addr (pre_addr), .pre_wdata (pre_wdata), .dbg_pc (dbg_pc),
    .dbg_rf_we (dbg_rf_we), .dbg_rf_waddr (dbg_rf_waddr), .dbg_rf_wdata (dbg_rf_wdata)
  );

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  logic [31:0] m_imem [WORDS];
  logic [31:0] m_dmem [WORDS];
  logic [31:0] m_rf   [32];
  logic [31:0] m_pc;
  string       prev_tag;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == WATCHDOG) begin
      n_fail++;
      $display("FAIL R11 watchdog actual=%0d expected<%0d", cyc, WATCHDOG);
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  function automatic logic [31:0] enc_r(input logic [5:0] fn, input int rs, input int rt, input int rd);
    return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
  endfunction
  function automatic logic [31:0] enc_i(input logic [5:0] op, input int rs, input int rt, input logic [15:0] imm);
    return {op, 5'(rs), 5'(rt), imm};
  endfunction
  function automatic logic [31:0] enc_j(input int idx);
    return {6'h02, 26'(idx)};
  endfunction

  function automatic bit fn_ok(input logic [5:0] fn);
    return fn == 6'h20 || fn == 6'h22 || fn == 6'h24 || fn == 6'h25 || fn == 6'h26 || fn == 6'h27;
  endfunction

  // which requirement an instruction exercises
  function automatic string tag_of(input logic [31:0] w);
    logic [4:0] rs, rt, rd;
    rs = w[25:21]; rt = w[20:16]; rd = w[15:11];
    case (w[31:26])
      6'h00: if (!fn_ok(w[5:0])) return "R9";
             else if (rd == 0) return "R8";
             else if (rs == rd || rt == rd) return "R10";
             else return "R3";
      6'h08: return (rt == 0) ? "R8" : ((rs == rt) ? "R10" : "R4");
      6'h23: return (rt == 0) ? "R8" : "R5";
      6'h2B: return "R5";
      6'h04: return "R6";
      6'h02: return "R7";
      default: return "R9";
    endcase
  endfunction

  function automatic logic [31:0] rnd_inst(input int idx);
    logic [5:0] fl [6] = '{6'h20, 6'h22, 6'h24, 6'h25, 6'h26, 6'h27};
    int k, rs, rt, rd, off, tgt;
    k = int'($urandom % 16);
    rs = int'($urandom % 8); rt = int'($urandom % 8); rd = int'($urandom % 8);
    case (k)
      0, 1, 2, 3, 4: return enc_r(fl[$urandom % 6], rs, rt, rd);
      5:             return enc_r(6'($urandom), rs, rt, rd);
      6, 7:          return enc_i(6'h08, rs, rt, 16'($urandom));
      8, 9:          return enc_i(6'h23, rs, rt, 16'($urandom));
      10, 11:        return enc_i(6'h2B, rs, rt, 16'($urandom));
      12, 13: begin
        off = int'($urandom % 13) - 6;
        if (off == -1) off = 3;
        return enc_i(6'h04, rs, rt, 16'(off));
      end
      14: begin
        tgt = int'($urandom % WORDS);
        if (tgt == idx) tgt = (idx + 1) % WORDS;
        return enc_j(tgt);
      end
      default: return $urandom;
    endcase
  endfunction

  task automatic do_reset();
    rst_n = 1'b0;
    #1;
    chk(dbg_pc == 32'd0, "R1", "async reset pc", dbg_pc, 32'd0);
    chk(!dbg_rf_we, "R1", "async reset we", 32'(dbg_rf_we), 32'd0);
    for (int i = 0; i < 2 * WORDS; i++) begin
      @(negedge clk);
      pre_we    = 1'b1;
      pre_dmem  = (i >= WORDS);
      pre_addr  = 8'(i % WORDS);
      pre_wdata = (i < WORDS) ? m_imem[i] : m_dmem[i - WORDS];
    end
    @(negedge clk);
    pre_we = 1'b0;
    chk(dbg_pc == 32'd0, "R1", "pc in reset", dbg_pc, 32'd0);
    for (int r = 0; r < 32; r++) m_rf[r] = '0;
    m_pc = '0;
    prev_tag = "R1";
    rst_n = 1'b1;
    @(negedge clk);
    chk(dbg_pc == 32'd0 && !dbg_rf_we, "R1", "sync hold pc/we", {dbg_pc[30:0], dbg_rf_we}, 32'd0);
    @(negedge clk);
  endtask

  // lockstep comparison against an instruction-level model
  task automatic run_lock(input int n, input bit junk);
    logic [31:0] w, sx, rsv, rtv, ea, nxt, wd, p4;
    logic [4:0]  wa;
    bit          we, st;
    string       tg;
    for (int c = 0; c < n; c++) begin
      w   = m_imem[m_pc[9:2]];
      rsv = m_rf[w[25:21]];
      rtv = m_rf[w[20:16]];
      sx  = {{16{w[15]}}, w[15:0]};
      ea  = rsv + sx;
      p4  = m_pc + 32'd4;
      nxt = p4; we = 1'b0; st = 1'b0; wa = w[20:16]; wd = '0;
      tg  = tag_of(w);
      case (w[31:26])
        6'h00: begin
          wa = w[15:11];
          we = fn_ok(w[5:0]);
          case (w[5:0])
            6'h20: wd = rsv + rtv;
            6'h22: wd = rsv - rtv;
            6'h24: wd = rsv & rtv;
            6'h25: wd = rsv | rtv;
            6'h26: wd = rsv ^ rtv;
            default: wd = ~(rsv | rtv);
          endcase
        end
        6'h08: begin we = 1'b1; wd = ea; end
        6'h23: begin we = 1'b1; wd = m_dmem[ea[9:2]]; end
        6'h2B: st = 1'b1;
        6'h04: if (rsv == rtv) nxt = p4 + {sx[29:0], 2'b00};
        6'h02: nxt = {p4[31:28], w[25:0], 2'b00};
        default: ;
      endcase
      if (wa == 5'd0) we = 1'b0;  // R8 discard
      chk(dbg_pc == m_pc, prev_tag, "pc", dbg_pc, m_pc);  // R11 plus next-PC of prior instr
      if (we) begin
        chk(dbg_rf_we && dbg_rf_waddr == wa, tg, "write enable/dest",
            {26'd0, dbg_rf_we, dbg_rf_waddr}, {26'd0, 1'b1, wa});
        chk(dbg_rf_wdata == wd, tg, "write data", dbg_rf_wdata, wd);
      end else begin
        chk(!dbg_rf_we, tg, "no write", 32'(dbg_rf_we), 32'd0);
      end
      if (we) m_rf[wa] = wd;
      if (st) m_dmem[ea[9:2]] = rtv;
      m_pc = nxt;
      prev_tag = tg;
      if (junk) begin
        // R2: preload strobes while running must not touch either memory
        pre_we    = 1'b1;
        pre_dmem  = c[0];
        pre_addr  = 8'(c % 32);
        pre_wdata = $urandom;
      end
      @(negedge clk);
    end
    pre_we = 1'b0;
  endtask

  task automatic load_directed();
    for (int i = 0; i < WORDS; i++) begin
      m_imem[i] = enc_i(6'h08, 15, 15, 16'd1);
      m_dmem[i] = $urandom;
    end
    m_imem[0]  = enc_i(6'h08, 0, 1, 16'd5);         // R4
    m_imem[1]  = enc_i(6'h08, 0, 2, 16'hFFFD);      // R4 negative immediate
    m_imem[2]  = enc_r(6'h20, 1, 2, 3);             // R3
    m_imem[3]  = enc_r(6'h22, 1, 2, 4);
    m_imem[4]  = enc_r(6'h24, 1, 2, 5);
    m_imem[5]  = enc_r(6'h25, 1, 2, 6);
    m_imem[6]  = enc_r(6'h26, 1, 2, 7);
    m_imem[7]  = enc_r(6'h27, 1, 2, 8);
    m_imem[8]  = enc_i(6'h08, 1, 0, 16'd7);         // R8
    m_imem[9]  = enc_r(6'h20, 1, 2, 0);             // R8
    m_imem[10] = enc_i(6'h2B, 0, 1, 16'd8);         // R5 store
    m_imem[11] = enc_i(6'h23, 0, 10, 16'd8);        // R5 load sees store
    m_imem[12] = enc_i(6'h23, 3, 11, 16'd4);        // R5 preloaded word
    m_imem[13] = enc_r(6'h20, 1, 1, 1);             // R10
    m_imem[14] = enc_i(6'h04, 1, 1, 16'd2);         // R6 taken
    m_imem[15] = enc_i(6'h08, 0, 12, 16'd99);
    m_imem[16] = enc_i(6'h08, 0, 12, 16'd99);
    m_imem[17] = enc_i(6'h04, 1, 2, 16'd5);         // R6 not taken
    m_imem[18] = 32'hFC00_0000;                     // R9 unknown opcode
    m_imem[19] = enc_r(6'h00, 1, 2, 12);            // R9 unknown funct
    m_imem[20] = enc_i(6'h08, 0, 13, 16'd64);
    m_imem[21] = enc_i(6'h2B, 13, 4, 16'hFFF8);     // R5 negative offset
    m_imem[22] = enc_i(6'h23, 13, 14, 16'hFFF8);
    m_imem[23] = enc_j(30);                         // R7
    m_imem[30] = enc_i(6'h04, 0, 0, 16'hFFFF);      // R6 branch to self
  endtask

  initial begin
    void'($urandom(32'd7341));
    load_directed();
    do_reset();
    run_lock(60, 1'b1);

    for (int ph = 0; ph < 2; ph++) begin
      for (int i = 0; i < WORDS; i++) begin
        m_imem[i] = rnd_inst(i);
        m_dmem[i] = $urandom;
      end
      do_reset();
      run_lock(2500, 1'b0);
    end

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule